// File: doc/BRIEF.md
# Tagged Receive Silo with Depth and Age Interrupts

This block is one shared receive queue for a group of serial lines. Each time a line receiver finishes a character it pushes a word into the queue. The word holds the character, the number of the line it came in on, and that line's receive error flags. The host drains the queue one word at a time through a single read window. Each read strobe removes the word currently shown in the window.

Two programmable conditions decide when the host should be interrupted:

- **Depth condition:** the fill level has reached a threshold.
- **Age condition:** the queue has been non-empty for more ticks of a periodic time base than a limit allows.

The age count starts at zero whenever the queue goes from empty to occupied, so it measures time since the queue was last empty. A status word reports the fill level, the two condition flags and a sticky overflow flag. The interrupt-pending output is high while either condition holds.

Top module: `rx_silo`

## Requirements
- R1: After a synchronous active-high reset, the level is 0, the depth, age and overflow flags are 0, the pending output is 0 and the window valid bit is 0.
- R2: Words come out of the window in the order they were written, with every field unchanged: an 8-bit character, a 4-bit line number and a 3-bit error field.
- R3: While the queue holds at least one word, the window shows the oldest word with valid set. A pop strobe removes exactly that word, and the change is visible one clock later.
- R4: A pop strobe while the queue is empty returns valid clear and leaves the level at 0.
- R5: The level counts stored words from 0 up to a capacity of 2048. A write and a pop in the same cycle on a non-empty, non-full queue leave the level unchanged.
- R6: The depth flag is set while the threshold is non-zero and the level is greater than or equal to it. A threshold of 0 disables the depth condition.
- R7: The age count is held at 0 while the queue is empty and advances by one per tick while it is non-empty. The age flag is set while the limit is non-zero, the queue is non-empty and the count is strictly greater than the limit. A limit of 0 disables the age condition.
- R8: The interrupt-pending output is high exactly when the depth flag or the age flag is high.
- R9: A write while the queue is full is dropped, the stored words are unchanged, and the overflow flag is set. The overflow flag stays set until reset, even after the queue drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push strobe from the line receivers |
| wr_char | input | 8 | Received character |
| wr_line | input | 4 | Originating line number |
| wr_err | input | 3 | Receive error flags |
| rd_pop | input | 1 | Host read strobe, removes the word in the window |
| depth_thresh | input | 12 | Depth threshold, 0 disables |
| age_limit | input | 16 | Age limit in ticks, 0 disables |
| tick | input | 1 | Periodic time base pulse |
| win_valid | output | 1 | Window holds a word |
| win_char | output | 8 | Window character |
| win_line | output | 4 | Window line number |
| win_err | output | 3 | Window error flags |
| stat_level | output | 12 | Current fill level |
| stat_depth_hit | output | 1 | Depth condition met |
| stat_age_hit | output | 1 | Age condition met |
| stat_overflow | output | 1 | Sticky overflow flag |
| irq_pend | output | 1 | Silo interrupt pending |

## Verification
A corrupted read or write pointer shows up in the window at once: the next popped word carries the wrong character or line tag. An off-by-one in the level counter moves the depth flag one write early or late, and it also makes the window claim valid data on an empty queue. An age counter that misses the clear on empty shows up as an age flag raised after fewer ticks than the limit, in the first occupancy after a drain. Dropping words on full is only visible after a full drain, when the last word out must be the last one that fit.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

    localparam int CHAR_W = 8;
    localparam int LINE_W = 4;
    localparam int ERR_W  = 3;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } silo_word_t;

    typedef struct packed {
        logic       valid;
        silo_word_t word;
    } silo_window_t;

    // Threshold test where a zero threshold means "disabled".
    function automatic logic at_or_above(input int unsigned value,
                                         input int unsigned thresh);
        return (thresh != 0) && (value >= thresh);
    endfunction

    // Limit test where a zero limit means "disabled".
    function automatic logic strictly_above(input int unsigned value,
                                            input int unsigned limit);
        return (limit != 0) && (value > limit);
    endfunction

endpackage

// File: rtl/silo_store.sv
module silo_store
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  silo_word_t       push_word,
    input  logic             pop_req,
    output silo_window_t     head,
    output logic [LVL_W-1:0] level,
    output logic             overflow
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    silo_word_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, empty, push_ok, pop_ok;

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        logic [PTR_W-1:0] r;
        if ((DEPTH & (DEPTH - 1)) == 0) r = p + 1'b1;
        else                            r = (p == LAST_PTR) ? '0 : p + 1'b1;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push_req && full) overflow <= 1'b1;
        end
    end

    always_comb begin
        head.valid = !empty;
        head.word  = empty ? '0 : mem[rd_ptr];
    end

endmodule

// File: rtl/silo_age_timer.sv
module silo_age_timer #(
    parameter int AGE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             occupied,
    output logic [AGE_W-1:0] age
);

    always_ff @(posedge clk) begin
        if (rst || !occupied) age <= '0;
        else if (tick && (age != '1)) age <= age + 1'b1;
    end

endmodule

// File: rtl/silo_irq_eval.sv
module silo_irq_eval
    import rx_silo_pkg::*;
#(
    parameter int LVL_W = 12,
    parameter int AGE_W = 16
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] depth_thresh,
    input  logic [AGE_W-1:0] age,
    input  logic [AGE_W-1:0] age_limit,
    output logic             depth_hit,
    output logic             age_hit,
    output logic             irq
);

    always_comb begin
        depth_hit = at_or_above(int'(level), int'(depth_thresh));
        age_hit   = (level != '0) && strictly_above(int'(age), int'(age_limit));
        irq       = depth_hit || age_hit;
    end

endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AGE_W = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd_pop,
    input  logic [LVL_W-1:0]  depth_thresh,
    input  logic [AGE_W-1:0]  age_limit,
    input  logic              tick,
    output logic              win_valid,
    output logic [CHAR_W-1:0] win_char,
    output logic [LINE_W-1:0] win_line,
    output logic [ERR_W-1:0]  win_err,
    output logic [LVL_W-1:0]  stat_level,
    output logic              stat_depth_hit,
    output logic              stat_age_hit,
    output logic              stat_overflow,
    output logic              irq_pend
);

    silo_word_t       in_word;
    silo_window_t     head;
    logic [AGE_W-1:0] age;

    assign in_word = '{err: wr_err, line: wr_line, ch: wr_char};

    silo_store #(.DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_en),
        .push_word (in_word),
        .pop_req   (rd_pop),
        .head      (head),
        .level     (stat_level),
        .overflow  (stat_overflow)
    );

    silo_age_timer #(.AGE_W(AGE_W)) age_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .occupied (stat_level != '0),
        .age      (age)
    );

    silo_irq_eval #(.LVL_W(LVL_W), .AGE_W(AGE_W)) irq_i (
        .level        (stat_level),
        .depth_thresh (depth_thresh),
        .age          (age),
        .age_limit    (age_limit),
        .depth_hit    (stat_depth_hit),
        .age_hit      (stat_age_hit),
        .irq          (irq_pend)
    );

    assign win_valid = head.valid;
    assign win_char  = head.word.ch;
    assign win_line  = head.word.line;
    assign win_err   = head.word.err;

endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
    parameter int DEPTH = 2048,
    parameter int AGE_W = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_pop,
    input logic [LVL_W-1:0] depth_thresh,
    input logic             win_valid,
    input logic [LVL_W-1:0] stat_level,
    input logic             stat_depth_hit,
    input logic             stat_age_hit,
    input logic             stat_overflow,
    input logic             irq_pend
);

    // R3
    win_valid_tracks_level_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid == (stat_level != '0));

    // R4
    empty_pop_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !wr_en && stat_level == '0) |=> (stat_level == '0));

    // R5
    level_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        stat_level <= LVL_W'(DEPTH));

    // R5
    push_raises_level_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_pop && stat_level < LVL_W'(DEPTH))
            |=> (stat_level == $past(stat_level) + 1'b1));

    // R6
    depth_reaches_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (depth_thresh != '0 && stat_level >= depth_thresh) |-> irq_pend);

    // R7
    empty_never_aged_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_level == '0) |-> !stat_age_hit);

    // R8
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pend |-> (stat_depth_hit || stat_age_hit));

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stat_overflow |=> stat_overflow);

endmodule

bind rx_silo rx_silo_chk #(.DEPTH(DEPTH), .AGE_W(AGE_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .rd_pop         (rd_pop),
    .depth_thresh   (depth_thresh),
    .win_valid      (win_valid),
    .stat_level     (stat_level),
    .stat_depth_hit (stat_depth_hit),
    .stat_age_hit   (stat_age_hit),
    .stat_overflow  (stat_overflow),
    .irq_pend       (irq_pend)
);

// File: tb/rx_silo_tb_top.sv
module rx_silo_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_pop, tick;
    logic [7:0]  wr_char;
    logic [3:0]  wr_line;
    logic [2:0]  wr_err;
    logic [11:0] depth_thresh;
    logic [15:0] age_limit;
    logic        win_valid;
    logic [7:0]  win_char;
    logic [3:0]  win_line;
    logic [2:0]  win_err;
    logic [11:0] stat_level;
    logic        stat_depth_hit, stat_age_hit, stat_overflow, irq_pend;

    int compared = 0;
    int mismatched = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    rx_silo dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char), .wr_line(wr_line),
        .wr_err(wr_err), .rd_pop(rd_pop), .depth_thresh(depth_thresh),
        .age_limit(age_limit), .tick(tick), .win_valid(win_valid),
        .win_char(win_char), .win_line(win_line), .win_err(win_err),
        .stat_level(stat_level), .stat_depth_hit(stat_depth_hit),
        .stat_age_hit(stat_age_hit), .stat_overflow(stat_overflow),
        .irq_pend(irq_pend)
    );

    // {err, line, char}
    localparam logic [14:0] VEC [8] = '{
        {3'd0, 4'd0,  8'h41}, {3'd1, 4'd5,  8'h00}, {3'd7, 4'd15, 8'hFF},
        {3'd2, 4'd3,  8'h5A}, {3'd4, 4'd9,  8'hA5}, {3'd0, 4'd12, 8'h0D},
        {3'd5, 4'd1,  8'h7E}, {3'd3, 4'd7,  8'h33}
    };

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic w, input logic [14:0] d, input logic p, input logic t);
        wr_en = w; {wr_err, wr_line, wr_char} = d; rd_pop = p; tick = t;
        @(negedge clk);
        wr_en = 0; rd_pop = 0; tick = 0;
    endtask

    task automatic do_reset();
        rst = 1; step(0, '0, 0, 0); step(0, '0, 0, 0); rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        wr_en = 0; rd_pop = 0; tick = 0; wr_char = 0; wr_line = 0; wr_err = 0;
        depth_thresh = 0; age_limit = 0; rst = 1;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 level", stat_level, 0);
        check("R1 flags", {stat_depth_hit, stat_age_hit, stat_overflow, irq_pend}, 0);
        check("R1 valid", win_valid, 0);

        // R4 pop while empty
        step(0, '0, 1, 0);
        check("R4 level", stat_level, 0);
        check("R4 valid", win_valid, 0);

        // R2/R3/R5 vector table: write all, then drain in order
        for (int i = 0; i < 8; i++) begin
            step(1, VEC[i], 0, 0);
            check("R5 level up", stat_level, i + 1);
        end
        for (int i = 0; i < 8; i++) begin
            check("R3 valid", win_valid, 1);
            check("R2 word", {win_err, win_line, win_char}, VEC[i]);
            step(0, '0, 1, 0);
            check("R3 level down", stat_level, 7 - i);
        end
        check("R4 drained valid", win_valid, 0);

        // R5 simultaneous write and pop
        step(1, VEC[0], 0, 0);
        step(1, VEC[1], 1, 0);
        check("R5 same-cycle level", stat_level, 1);
        check("R2 same-cycle head", {win_err, win_line, win_char}, VEC[1]);
        step(0, '0, 1, 0);

        // R6 depth threshold
        depth_thresh = 12'd3;
        step(1, VEC[2], 0, 0);
        step(1, VEC[3], 0, 0);
        check("R6 below thresh", stat_depth_hit, 0);
        check("R8 no irq", irq_pend, 0);
        step(1, VEC[4], 0, 0);
        check("R6 at thresh", stat_depth_hit, 1);
        check("R8 irq depth", irq_pend, 1);
        depth_thresh = 12'd0;
        #1;
        check("R6 disabled", stat_depth_hit, 0);
        for (int i = 0; i < 3; i++) step(0, '0, 1, 0);

        // R7 age: limit 3
        age_limit = 16'd3;
        step(0, '0, 0, 1);
        step(0, '0, 0, 1);                 // ticks while empty must not count
        step(1, VEC[5], 0, 0);
        for (int i = 0; i < 3; i++) step(0, '0, 0, 1);
        check("R7 at limit", stat_age_hit, 0);
        step(0, '0, 0, 1);
        check("R7 over limit", stat_age_hit, 1);
        check("R8 irq age", irq_pend, 1);
        age_limit = 16'd0;
        #1;
        check("R7 disabled", stat_age_hit, 0);
        age_limit = 16'd3;
        step(0, '0, 1, 0);
        check("R7 empty clears", stat_age_hit, 0);
        step(1, VEC[6], 0, 0);
        for (int i = 0; i < 3; i++) step(0, '0, 0, 1);
        check("R7 restart from empty", stat_age_hit, 0);
        step(0, '0, 1, 0);
        age_limit = 16'd0;

        // R9 overflow: fill to 2048, then one extra write
        for (int i = 0; i < 2049; i++) step(1, {3'd0, 4'(i >> 8), 8'(i)}, 0, 0);
        check("R5 full level", stat_level, 2048);
        check("R9 overflow set", stat_overflow, 1);
        check("R2 first of full", {win_line, win_char}, 0);
        for (int i = 0; i < 2047; i++) step(0, '0, 1, 0);
        check("R9 last kept", {win_line, win_char}, 2047);
        step(0, '0, 1, 0);
        check("R9 extra dropped", win_valid, 0);
        check("R9 sticky", stat_overflow, 1);
        do_reset();
        check("R1 overflow cleared", stat_overflow, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule